// File: doc/BRIEF.md
# Split ROM/RAM Memory Subsystem

This block is the memory behind an 8-bit processor that uses a 16-bit address and active-low strobes. The address space is split into two halves. The lower half, from 0x0000 to 0x7FFF, is a read-only region whose contents come from a computed, synthesizable table. The upper half, from 0x8000 to 0xFFFF, is a read/write region. Address bit 15 picks the half, and only while the memory-request strobe is low. At most one region is enabled in any cycle.

The model is synchronous. Strobes and address are sampled on the rising clock edge. For a qualified read, the data and a drive-enable appear one clock later. While the drive-enable is low, the read data is zero, so a bus mux or tri-state can use the enable directly. A write to the upper half is stored at that edge. A write to the lower half is dropped, so the program store cannot be changed from the bus. Execution after reset starts at 0x0000, which sits in the read-only half.

The architectural size of each region is 32K bytes. The number of physical storage bytes per region is a parameter (`STORE_AW` address bits, default 8). Higher offset bits alias onto that storage.

Top module: `memsys_top`

## Requirements
- R1: After synchronous reset, `drive_en` is 0 and `rdata` is 0x00.
- R2: A cycle with `mreq_n`=0, `rd_n`=0 and `addr[15]`=0 returns the read-only byte one clock later, with `drive_en`=1. The byte is ((addr mod 2^STORE_AW) * 37 + 92) mod 256.
- R3: A read of address 0x0000, where execution starts after reset, returns 0x5C.
- R4: A cycle with `mreq_n`=0, `wr_n`=0 and `addr[15]`=1 stores `wdata`. A later read of the same address returns it one clock after the read cycle.
- R5: A write cycle with `addr[15]`=0 has no effect. A following read of that address still returns the table byte.
- R6: Read/write storage is indexed by `addr[STORE_AW-1:0]`, so addresses that differ only in bits 14..STORE_AW reach the same byte.
- R7: `drive_en` is 1 in a cycle only if the previous edge sampled `mreq_n`=0 and `rd_n`=0. With `mreq_n`=1 it is 0 in the next cycle, whatever `addr[15]` and `rd_n` are.
- R8: Whenever `drive_en` is 0, `rdata` is 0x00.
- R9: Bit 15 alone selects the region: 0x7FFF reads the table and 0x8000 reads read/write storage. At most one region is enabled in any cycle.
- R10: A low `wr_n` while `mreq_n`=1 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Bus address |
| wdata | input | 8 | Write data from the processor |
| mreq_n | input | 1 | Memory request strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rdata | output | 8 | Read data, zero while not driving |
| drive_en | output | 1 | Data bus drive enable |

## Verification
Every read result, and the drive-enable, is due exactly one clock after the edge that samples the strobes. A write takes effect at its own edge, so a read issued in the very next cycle already sees the new byte. The driver sets inputs on the falling edge and queues the expected enable and data for that cycle. The monitor takes one entry from the queue shortly after each rising edge and compares it with the outputs. Every expectation therefore lines up with the registered output of the cycle that produced it.

// File: rtl/memsys_pkg.sv
package memsys_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;

    // decoded bus cycle
    typedef struct packed {
        logic rom_en;
        logic ram_en;
        logic rd_ok;
        logic wr_ok;
    } dec_t;

    typedef enum logic {
        SRC_ROM = 1'b0,
        SRC_RAM = 1'b1
    } src_e;

    // computed read-only contents for a storage index
    function automatic logic [DATA_W-1:0] rom_pattern(input logic [ADDR_W-1:0] idx);
        logic [ADDR_W-1:0] v;
        v = idx * 16'd37 + 16'd92;
        return v[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/memsys_decode.sv
module memsys_decode
    import memsys_pkg::*;
(
    input  logic              mreq_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              hi_bit,
    output dec_t              dec
);

    always_comb begin
        dec        = '0;
        dec.rom_en = !mreq_n && !hi_bit;
        dec.ram_en = !mreq_n &&  hi_bit;
        dec.rd_ok  = !mreq_n && !rd_n;
        dec.wr_ok  = !mreq_n && !wr_n;
    end

endmodule

// File: rtl/memsys_rom.sv
module memsys_rom
    import memsys_pkg::*;
#(
    parameter int STORE_AW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_en,
    input  logic [STORE_AW-1:0] idx,
    output logic [DATA_W-1:0]   q
);

    localparam int DEPTH = 1 << STORE_AW;

    logic [DATA_W-1:0] tbl [DEPTH];

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_tbl
            assign tbl[i] = rom_pattern(ADDR_W'(i));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (rd_en)
            q <= tbl[idx];
    end

endmodule

// File: rtl/memsys_ram.sv
module memsys_ram
    import memsys_pkg::*;
#(
    parameter int STORE_AW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_en,
    input  logic                wr_en,
    input  logic [STORE_AW-1:0] idx,
    input  logic [DATA_W-1:0]   wd,
    output logic [DATA_W-1:0]   q
);

    localparam int DEPTH = 1 << STORE_AW;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[idx] <= wd;
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (rd_en)
            q <= mem[idx];
    end

endmodule

// File: rtl/memsys_top.sv
module memsys_top
    import memsys_pkg::*;
#(
    parameter int STORE_AW = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               mreq_n,
    input  logic               rd_n,
    input  logic               wr_n,
    output logic [DATA_W-1:0]  rdata,
    output logic               drive_en
);

    localparam int HI_BIT = ADDR_W - 1;

    dec_t              dec;
    logic [DATA_W-1:0] rom_q;
    logic [DATA_W-1:0] ram_q;
    src_e              src_q;
    logic              rom_rd, ram_rd, ram_wr;

    memsys_decode u_dec (
        .mreq_n (mreq_n),
        .rd_n   (rd_n),
        .wr_n   (wr_n),
        .hi_bit (addr[HI_BIT]),
        .dec    (dec)
    );

    assign rom_rd = dec.rom_en && dec.rd_ok;
    assign ram_rd = dec.ram_en && dec.rd_ok;
    assign ram_wr = dec.ram_en && dec.wr_ok;

    memsys_rom #(.STORE_AW(STORE_AW)) u_rom (
        .clk   (clk),
        .rst   (rst),
        .rd_en (rom_rd),
        .idx   (addr[STORE_AW-1:0]),
        .q     (rom_q)
    );

    memsys_ram #(.STORE_AW(STORE_AW)) u_ram (
        .clk   (clk),
        .rst   (rst),
        .rd_en (ram_rd),
        .wr_en (ram_wr),
        .idx   (addr[STORE_AW-1:0]),
        .wd    (wdata),
        .q     (ram_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            drive_en <= 1'b0;
            src_q    <= SRC_ROM;
        end else begin
            drive_en <= dec.rd_ok;
            if (dec.rd_ok)
                src_q <= dec.ram_en ? SRC_RAM : SRC_ROM;
        end
    end

    always_comb begin
        if (!drive_en)
            rdata = '0;
        else if (src_q == SRC_RAM)
            rdata = ram_q;
        else
            rdata = rom_q;
    end

    AST_ONE_REGION: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dec.rom_en, dec.ram_en})); // R9

    AST_DRIVE_QUAL: assert property (@(posedge clk) disable iff (rst)
        drive_en |-> $past(!mreq_n && !rd_n)); // R7

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        mreq_n |=> !drive_en); // R7

    AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
        !drive_en |-> (rdata == '0)); // R8

    AST_WRITE_HIGH: assert property (@(posedge clk) disable iff (rst)
        ram_wr |-> (addr[HI_BIT] && !mreq_n)); // R5

    AST_NO_STRAY_WRITE: assert property (@(posedge clk) disable iff (rst)
        mreq_n |-> !ram_wr); // R10

endmodule

// File: tb/tb_memsys_top.sv
module tb_memsys_top;

    localparam int SAW = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        mreq_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [7:0]  rdata;
    logic        drive_en;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic       en;
        logic [7:0] data;
        string      req;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    memsys_top #(.STORE_AW(SAW)) dut (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata),
        .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n),
        .rdata(rdata), .drive_en(drive_en)
    );

    function automatic logic [7:0] table_byte(input logic [15:0] a);
        int v;
        v = (int'(a) % (1 << SAW)) * 37 + 92;
        return 8'(v % 256);
    endfunction

    // driver: one bus cycle, expectation for the result one clock later
    task automatic bus(input logic m, input logic r, input logic w,
                       input logic [15:0] a, input logic [7:0] d,
                       input logic e_en, input logic [7:0] e_dat, input string req);
        exp_t x;
        @(negedge clk);
        mreq_n = m; rd_n = r; wr_n = w; addr = a; wdata = d;
        x.en = e_en; x.data = e_dat; x.req = req;
        sb.push_back(x);
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] e, input string req);
        bus(1'b0, 1'b0, 1'b1, a, 8'h00, 1'b1, e, req);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input string req);
        bus(1'b0, 1'b1, 1'b0, a, d, 1'b0, 8'h00, req);
    endtask

    task automatic idle(input string req);
        bus(1'b1, 1'b1, 1'b1, 16'h0000, 8'h00, 1'b0, 8'h00, req);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t x;
                x = sb.pop_front();
                checks++;
                if (drive_en !== x.en || rdata !== x.data) begin
                    errors++;
                    $display("FAIL %s: got en=%0b data=%02h expected en=%0b data=%02h",
                             x.req, drive_en, rdata, x.en, x.data);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        checks++;
        if (drive_en !== 1'b0 || rdata !== 8'h00) begin
            errors++;
            $display("FAIL R1: got en=%0b data=%02h expected en=0 data=00", drive_en, rdata);
        end
        @(negedge clk);
        rst = 1'b0;

        idle("R1");
        // R3 reset vector
        rd(16'h0000, 8'h5C, "R3");
        // R2 table reads
        rd(16'h0001, table_byte(16'h0001), "R2");
        rd(16'h0042, table_byte(16'h0042), "R2");
        rd(16'h12FF, table_byte(16'h12FF), "R2");
        // R9 boundary
        wr(16'h8000, 8'hC3, "R4");
        rd(16'h7FFF, table_byte(16'h7FFF), "R9");
        rd(16'h8000, 8'hC3, "R9");
        // R4 write then immediate read, several patterns
        wr(16'h8010, 8'hA5, "R4");
        rd(16'h8010, 8'hA5, "R4");
        wr(16'hFFFF, 8'h3C, "R4");
        wr(16'h9001, 8'h00, "R4");
        rd(16'hFFFF, 8'h3C, "R4");
        rd(16'h9001, 8'h00, "R4");
        // R5 write to lower half ignored
        wr(16'h0010, 8'h11, "R5");
        rd(16'h0010, table_byte(16'h0010), "R5");
        rd(16'h8010, 8'hA5, "R5");
        // R6 aliasing
        wr(16'h8005, 8'h77, "R6");
        rd(16'h8105, 8'h77, "R6");
        rd(16'hC005, 8'h77, "R6");
        // R7 idle strobes
        bus(1'b1, 1'b0, 1'b1, 16'h8010, 8'h00, 1'b0, 8'h00, "R7");
        bus(1'b1, 1'b0, 1'b1, 16'h0000, 8'h00, 1'b0, 8'h00, "R7");
        // R8 mreq low but no read strobe: no drive, zero data
        bus(1'b0, 1'b1, 1'b1, 16'h8010, 8'h00, 1'b0, 8'h00, "R8");
        // R10 write strobe without mreq stores nothing
        bus(1'b1, 1'b1, 1'b0, 16'h8010, 8'hEE, 1'b0, 8'h00, "R10");
        rd(16'h8010, 8'hA5, "R10");
        idle("R8");
        idle("R8");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule